// File: doc/BRIEF.md
# Concatenated-Index Correlating Branch Direction Predictor

This block guesses whether a conditional branch is taken and learns from the real result in the same event. Each event arrives as a one-cycle strobe. The strobe carries the address of the branch instruction and the actual taken bit. The block builds a table index from two parts. The recent global taken/not-taken history sits in the upper index bits. A slice of the instruction address, with the always-zero alignment bits removed, sits in the lower index bits. The block reads a 2-bit saturating counter at that index, and the top bit of the counter is the guess. It then reports whether the guess was wrong, trains the counter toward the real outcome and shifts the outcome into the history.

The result appears one cycle after the strobe, together with a valid pulse. Two running totals are also kept: accepted events and wrong guesses. A synchronous reset clears the history and the totals at once. The counter table is then cleared by a sweep that writes one entry per cycle. A busy output stays high during the sweep, and strobes seen while busy is high are dropped.

Top module: `corr_dir_pred`

## Requirements
- R1: The table index is {history[HIST_W-1:0], in_pc[ALIGN_LSB+PC_BITS-1:ALIGN_LSB]}, with the history in the upper bits. Address bits below ALIGN_LSB, and bits above the slice, do not affect the index.
- R2: The guess is taken when the selected counter holds 2 or 3, and not taken when it holds 0 or 1. The guess is reported on out_pred_taken.
- R3: For each accepted strobe, out_valid is high for exactly one cycle on the following cycle. In that cycle, out_mispredict is 1 when the guess differs from in_taken and 0 otherwise.
- R4: A taken outcome raises the selected counter by one, up to a ceiling of 3. A not-taken outcome lowers it by one, down to a floor of 0.
- R5: After each accepted event, the history shifts left by one position and the actual outcome enters bit 0.
- R6: An event accepted in the cycle right after another event that used the same index sees the counter value as already trained by that earlier event.
- R7: event_count counts accepted events and holds at all-ones instead of wrapping.
- R8: miss_count counts accepted events whose guess was wrong, holds at all-ones, and never exceeds event_count.
- R9: Reset clears the history and both totals. After reset is released, busy is high for exactly 2^(HIST_W+PC_BITS) cycles, during which one table entry per cycle is set to 0. Strobes seen while busy is high produce no output, change no total and train nothing.
- R10: out_valid stays low in any cycle that does not follow an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Branch resolution strobe |
| in_pc | input | ADDR_W | Branch instruction address |
| in_taken | input | 1 | Actual outcome, 1 = taken |
| busy | output | 1 | Table clear sweep in progress; inputs are dropped |
| out_valid | output | 1 | Result pulse, one cycle after an accepted strobe |
| out_pred_taken | output | 1 | Guess that was made for the event |
| out_mispredict | output | 1 | Guess differed from the actual outcome |
| event_count | output | CNT_W | Saturating total of accepted events |
| miss_count | output | CNT_W | Saturating total of wrong guesses |

## Verification
The bench first drives strobes during the clear sweep. A design that does not gate its inputs on busy would emit results, raise the totals or leave trained state behind. It then repeats one branch until the history is saturated, so that the same entry is hit on back-to-back cycles. A design that read a stale counter there would be late to flip its guess and would report extra mispredicts. Random addresses vary the alignment bits and the bits above the index slice, which catches a wrong or shifted address slice. Enough events are applied to reach the all-ones ceiling of the narrowed totals, so a design that wraps would drop back to small values. A second reset after training checks that the sweep really clears every entry; stale counters would show up as taken guesses.

// File: rtl/corr_dir_pred.sv
module corr_dir_pred #(
  parameter int HIST_W    = 5,
  parameter int PC_BITS   = 5,
  parameter int ALIGN_LSB = 2,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_taken,
  output logic              busy,
  output logic              out_valid,
  output logic              out_pred_taken,
  output logic              out_mispredict,
  output logic [CNT_W-1:0]  event_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = HIST_W + PC_BITS;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [1:0]        pht [DEPTH];
  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  sweep_ptr;
  logic              sweeping;
  logic [1:0]        nxt;

  wire              accept = in_valid & ~sweeping;
  wire [IDX_W-1:0]  idx    = {ghist, in_pc[ALIGN_LSB +: PC_BITS]};
  wire [1:0]        cur    = pht[idx];
  wire              pred   = cur[1];
  wire              wrong  = pred ^ in_taken;

  assign busy = sweeping;

  always_comb begin
    nxt = cur;
    if (in_taken) begin
      if (cur != 2'd3) nxt = cur + 2'd1;
    end else begin
      if (cur != 2'd0) nxt = cur - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (sweeping)    pht[sweep_ptr] <= 2'd0;
      else if (accept) pht[idx]       <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping       <= 1'b1;
      sweep_ptr      <= '0;
      ghist          <= '0;
      out_valid      <= 1'b0;
      out_pred_taken <= 1'b0;
      out_mispredict <= 1'b0;
      event_count    <= '0;
      miss_count     <= '0;
    end else begin
      out_valid <= accept;
      if (sweeping) begin
        sweep_ptr <= sweep_ptr + 1'b1;
        if (sweep_ptr == LAST) sweeping <= 1'b0;
      end
      if (accept) begin
        ghist          <= {ghist[HIST_W-2:0], in_taken};
        out_pred_taken <= pred;
        out_mispredict <= wrong;
        if (!(&event_count))         event_count <= event_count + 1'b1;
        if (wrong && !(&miss_count)) miss_count  <= miss_count + 1'b1;
      end
    end
  end

  a_r3_miss_matches_outcome: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_mispredict == (out_pred_taken ^ $past(in_taken)));

  a_r5_history_takes_outcome: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ghist[0] == $past(in_taken));

  a_r7_event_holds_at_top: assert property (@(posedge clk) disable iff (rst)
    (&event_count) |=> (&event_count));

  a_r7_event_steps_on_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(&$past(event_count))) |-> event_count == $past(event_count) + 1'b1);

  a_r8_miss_bounded: assert property (@(posedge clk) disable iff (rst)
    miss_count <= event_count);

  a_r9_busy_blocks_output: assert property (@(posedge clk) disable iff (rst)
    busy |=> !out_valid);

  a_r10_no_result_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

// File: tb/corr_dir_pred_bench.sv
module corr_dir_pred_bench;
  localparam int H  = 4;
  localparam int P  = 4;
  localparam int A  = 2;
  localparam int CW = 8;
  localparam int NT = 1 << (H + P);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_pc = '0;
  logic in_taken = 1'b0;
  logic busy, out_valid, out_pred_taken, out_mispredict;
  logic [CW-1:0] event_count, miss_count;

  corr_dir_pred #(.HIST_W(H), .PC_BITS(P), .ALIGN_LSB(A), .ADDR_W(32), .CNT_W(CW)) u_corr_dir_pred (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pc(in_pc), .in_taken(in_taken),
    .busy(busy), .out_valid(out_valid), .out_pred_taken(out_pred_taken),
    .out_mispredict(out_mispredict), .event_count(event_count), .miss_count(miss_count));

  always #4 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int mctr [NT];
  int mhist, sweep_left, mev, mmiss;
  bit e_valid, e_pred, e_miss;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NT; i++) mctr[i] = 0;
    mhist = 0; mev = 0; mmiss = 0; sweep_left = NT;
    e_valid = 0;
  endtask

  task automatic step(input bit v, input logic [31:0] pc, input bit t);
    int ix;
    bit acc;
    in_valid = v; in_pc = pc; in_taken = t;
    acc = v && (sweep_left == 0);
    e_valid = acc;
    if (acc) begin
      ix = ((mhist & ((1 << H) - 1)) << P) | ((pc >> A) & ((1 << P) - 1));
      e_pred = mctr[ix] >= 2;
      e_miss = e_pred != t;
      if (t && mctr[ix] < 3) mctr[ix]++;
      if (!t && mctr[ix] > 0) mctr[ix]--;
      mhist = ((mhist << 1) | int'(t)) & ((1 << H) - 1);
      if (mev < CMAX) mev++;
      if (e_miss && mmiss < CMAX) mmiss++;
    end
    if (sweep_left > 0) sweep_left--;
    @(negedge clk);
    chk("R9 busy", int'(busy), int'(sweep_left > 0));
    chk("R3/R10 out_valid", int'(out_valid), int'(e_valid));
    chk("R7 event_count", int'(event_count), mev);
    chk("R8 miss_count", int'(miss_count), mmiss);
    if (e_valid) begin
      chk("R2 out_pred_taken", int'(out_pred_taken), int'(e_pred));
      chk("R3 out_mispredict", int'(out_mispredict), int'(e_miss));
    end
  endtask

  task automatic do_reset();
    in_valid = 0;
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    chk("R9 reset busy", int'(busy), 1);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset event_count", int'(event_count), 0);
    chk("R9 reset miss_count", int'(miss_count), 0);
    rst = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // R9: strobes during the sweep are dropped
    for (int i = 0; i < NT + 4; i++) step(1'b1, 32'(i * 4), i[0]);
    // R6/R4: repeated taken branch, back-to-back on one entry
    for (int i = 0; i < 12; i++) step(1'b1, 32'h0000_1010, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 32'h0000_1010, 1'b0);
    // R5: alternating outcomes with idle gaps
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 32'h0000_2024, i[0]);
      step(1'b0, 32'h0, 1'b0);
    end
    // R1: alias bits below and above the slice
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 7);
      logic [31:0] pc = 32'(sel << A) | 32'($urandom_range(0, 3)) | (32'($urandom) << (A + P));
      bit t = (sel % 3 != 0) ^ ($urandom_range(0, 7) == 0);
      step(1'b1, pc, t);
    end
    // R7/R8: saturation with random traffic
    for (int i = 0; i < 500; i++) step(1'($urandom_range(0, 3) != 0), $urandom, 1'($urandom));
    chk("R7 event_count saturated", int'(event_count), CMAX);
    // R9: second reset clears trained table
    do_reset();
    for (int i = 0; i < NT; i++) step(1'b0, 32'h0, 1'b0);
    for (int i = 0; i < 200; i++) step(1'b1, $urandom, 1'($urandom));
    step(1'b0, 32'h0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule